// File: doc/BRIEF.md
# Two-Bank LED Brightness Serial Write Port

This block is a write-only I2C target that sets the brightness of two LED banks. A backlight bank takes a 5-bit level and a switch for its fourth LED. A flash bank takes a 7-bit level. The block oversamples SCL and SDA with a fast system clock, so the bus needs no clock domain of its own. The only thing it ever drives back onto the bus is the acknowledge bit, which it signals by pulling SDA low through `sda_oe`.

Each programming transaction carries three bytes between one START and one STOP. The first byte is the device write address. The second byte picks the bank. The third byte is the value. The chosen register takes the value on the eighth SCL rising edge of the third byte. It does not wait for the acknowledge bit or the STOP. A fourth output turns the charge-pump converter on whenever either bank has a nonzero level. All outputs come from registers.

Top module: `ledbank_i2c_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when it equals 0x72 (7-bit address 0x39 with a write bit of 0). Any other address, including the read form 0x73, gets no acknowledge on that byte or on any later byte, and changes no output.
- R2: Bits are sampled MSB first on SCL rising edges. For an accepted byte, `sda_oe` goes high while SCL is low after the eighth bit. It stays steady through the ninth SCL high phase and drops at the next SCL falling edge.
- R3: A select byte of 0x01 targets the backlight register and 0x02 targets the flash register. Any other select value is not acknowledged, and the third byte is then neither acknowledged nor stored.
- R4: A backlight write stores data bits [4:0] as `bl_level` and data bit 7 as `bl_led4_en`. Data bits [6:5] are ignored.
- R5: A flash write stores data bits [6:0] as `fl_level`. Data bit 7 is ignored.
- R6: The targeted register is updated within six clock cycles of the eighth SCL rising edge of the third byte, while SCL is still high and before the acknowledge bit or STOP.
- R7: A STOP or repeated START that arrives before that edge aborts the frame without any update. Bytes after the third are not acknowledged and have no effect.
- R8: `pump_en` is 1 when `bl_level` or `fl_level` is nonzero and 0 when both are zero, whatever the state of `bl_led4_en`.
- R9: Synchronous reset clears `bl_level`, `bl_led4_en`, `fl_level`, `pump_en` and `sda_oe`.
- R10: A write to one bank leaves the other bank's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| bl_level | output | 5 | Backlight brightness code |
| bl_led4_en | output | 1 | Fourth backlight LED connected |
| fl_level | output | 7 | Flash brightness code |
| pump_en | output | 1 | Converter enable |

## Verification
Two events can fall together: the register commit and the end of the frame. The commit fires on the last data rising edge. A STOP or repeated START can follow it while SCL is still high, or can come one bit early. The bench reads the outputs mid-way through that final SCL high phase, before any STOP, and expects the new value already present. It also sends a STOP after only five data bits and a repeated START after three data bits, and expects both banks to stay unchanged. A fourth byte sent after a completed frame must get no acknowledge and leave the stored value alone.

// File: rtl/ledbank_i2c_pkg.sv
package ledbank_i2c_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_ACK, RX_SKIP} rx_state_t;
  typedef enum logic [1:0] {SLOT_DEV, SLOT_SEL, SLOT_VAL} byte_slot_t;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/ledbank_bus_sync.sv
module ledbank_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain[0] <= 1'b1;
          sda_chain[0] <= 1'b1;
        end else begin
          scl_chain[0] <= scl_in;
          sda_chain[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain[g] <= 1'b1;
          sda_chain[g] <= 1'b1;
        end else begin
          scl_chain[g] <= scl_chain[g-1];
          sda_chain[g] <= sda_chain[g-1];
        end
      end
    end
  end

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ledbank_frame_rx.sv
module ledbank_frame_rx
  import ledbank_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR7 = 7'h39,
  parameter logic [7:0] SEL_BL    = 8'h01,
  parameter logic [7:0] SEL_FL    = 8'h02
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       ack_oe,
  output logic       commit_vld,
  output logic       commit_flash,
  output logic [7:0] commit_val
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR7, 1'b0};

  rx_state_t        state;
  byte_slot_t       slot;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       full;
  logic             last_bit;
  logic             accept;

  assign full     = {shreg[6:0], sda_s};
  assign last_bit = (bitcnt == LAST_BIT);

  always_comb begin
    unique case (slot)
      SLOT_DEV: accept = (full == ADDR_WR);
      SLOT_SEL: accept = (full == SEL_BL) || (full == SEL_FL);
      default:  accept = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RX_IDLE;
      slot         <= SLOT_DEV;
      bitcnt       <= '0;
      shreg        <= '0;
      ack_oe       <= 1'b0;
      commit_vld   <= 1'b0;
      commit_flash <= 1'b0;
      commit_val   <= '0;
    end else begin
      commit_vld <= 1'b0;
      if (start_det) begin
        state  <= RX_SHIFT;
        slot   <= SLOT_DEV;
        bitcnt <= '0;
        ack_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= RX_IDLE;
        ack_oe <= 1'b0;
      end else begin
        unique case (state)
          RX_SHIFT: begin
            if (scl_rise) begin
              shreg  <= full;
              bitcnt <= bitcnt + 1'b1;
              if (last_bit) begin
                state <= accept ? RX_ACK : RX_SKIP;
                if (slot == SLOT_SEL) commit_flash <= (full == SEL_FL);
                if (slot == SLOT_VAL) begin
                  commit_vld <= 1'b1;
                  commit_val <= full;
                end
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              if (!ack_oe) begin
                ack_oe <= 1'b1;
              end else begin
                ack_oe <= 1'b0;
                bitcnt <= '0;
                if (slot == SLOT_VAL) begin
                  state <= RX_SKIP;
                end else begin
                  state <= RX_SHIFT;
                  slot  <= (slot == SLOT_DEV) ? SLOT_SEL : SLOT_VAL;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> $past(scl_rise)); // R6

  AST_ACK_BEGINS_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_oe) |-> !scl_s); // R2

  AST_ACK_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(ack_oe)); // R2
endmodule

// File: rtl/ledbank_regs.sv
module ledbank_regs #(
  parameter int unsigned BL_W     = 5,
  parameter int unsigned FL_W     = 7,
  parameter int unsigned LED4_BIT = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit_vld,
  input  logic            commit_flash,
  input  logic [7:0]      commit_val,
  output logic [BL_W-1:0] bl_level,
  output logic            bl_led4_en,
  output logic [FL_W-1:0] fl_level,
  output logic            pump_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bl_level   <= '0;
      bl_led4_en <= 1'b0;
      fl_level   <= '0;
    end else if (commit_vld) begin
      if (commit_flash) begin
        fl_level <= commit_val[FL_W-1:0];
      end else begin
        bl_level   <= commit_val[BL_W-1:0];
        bl_led4_en <= commit_val[LED4_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pump_en <= 1'b0;
    else     pump_en <= (bl_level != '0) || (fl_level != '0);
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_vld |=> ($stable(bl_level) && $stable(fl_level) && $stable(bl_led4_en))); // R7

  AST_BL_WRITE_KEEPS_FL: assert property (@(posedge clk) disable iff (rst)
    (commit_vld && !commit_flash) |=> $stable(fl_level)); // R10

  AST_FL_WRITE_KEEPS_BL: assert property (@(posedge clk) disable iff (rst)
    (commit_vld && commit_flash) |=> ($stable(bl_level) && $stable(bl_led4_en))); // R10

  AST_PUMP_AFTER_FLASH: assert property (@(posedge clk) disable iff (rst)
    (commit_vld && commit_flash && commit_val[FL_W-1:0] != '0) |-> ##2 pump_en); // R8
endmodule

// File: rtl/ledbank_i2c_ctrl.sv
module ledbank_i2c_ctrl #(
  parameter logic [6:0]  DEV_ADDR7   = 7'h39,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BL_W        = 5,
  parameter int unsigned FL_W        = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  output logic [BL_W-1:0] bl_level,
  output logic            bl_led4_en,
  output logic [FL_W-1:0] fl_level,
  output logic            pump_en
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit_vld, commit_flash;
  logic [7:0] commit_val;

  ledbank_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ledbank_frame_rx #(.DEV_ADDR7(DEV_ADDR7)) u_rx (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .ack_oe(sda_oe), .commit_vld(commit_vld),
    .commit_flash(commit_flash), .commit_val(commit_val)
  );

  ledbank_regs #(.BL_W(BL_W), .FL_W(FL_W)) u_regs (
    .clk(clk), .rst(rst), .commit_vld(commit_vld),
    .commit_flash(commit_flash), .commit_val(commit_val),
    .bl_level(bl_level), .bl_led4_en(bl_led4_en),
    .fl_level(fl_level), .pump_en(pump_en)
  );
endmodule

// File: tb/ledbank_i2c_ctrl_bench.sv
module ledbank_i2c_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NVEC = 13;

  // {addr, sel, data, acks{addr,sel,data}, bl, led4, fl, pump}
  localparam logic [40:0] VEC [NVEC] = '{
    {8'h72, 8'h01, 8'h9F, 3'b111, 5'h1F, 1'b1, 7'h00, 1'b1},
    {8'h72, 8'h02, 8'h7F, 3'b111, 5'h1F, 1'b1, 7'h7F, 1'b1},
    {8'h72, 8'h01, 8'h60, 3'b111, 5'h00, 1'b0, 7'h7F, 1'b1},
    {8'h72, 8'h02, 8'h80, 3'b111, 5'h00, 1'b0, 7'h00, 1'b0},
    {8'h70, 8'h01, 8'h15, 3'b000, 5'h00, 1'b0, 7'h00, 1'b0},
    {8'h73, 8'h01, 8'h15, 3'b000, 5'h00, 1'b0, 7'h00, 1'b0},
    {8'h72, 8'h03, 8'h15, 3'b100, 5'h00, 1'b0, 7'h00, 1'b0},
    {8'h72, 8'h00, 8'h15, 3'b100, 5'h00, 1'b0, 7'h00, 1'b0},
    {8'h72, 8'h01, 8'h80, 3'b111, 5'h00, 1'b1, 7'h00, 1'b0},
    {8'h72, 8'h02, 8'h01, 3'b111, 5'h00, 1'b1, 7'h01, 1'b1},
    {8'h72, 8'h01, 8'h0A, 3'b111, 5'h0A, 1'b0, 7'h01, 1'b1},
    {8'h72, 8'h02, 8'h00, 3'b111, 5'h0A, 1'b0, 7'h00, 1'b1},
    {8'h72, 8'h01, 8'h00, 3'b111, 5'h00, 1'b0, 7'h00, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, bl_led4_en, pump_en;
  logic [4:0] bl_level;
  logic [6:0] fl_level;
  logic sda_line;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledbank_i2c_ctrl u_ledbank_i2c_ctrl (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .bl_level(bl_level), .bl_led4_en(bl_led4_en),
    .fl_level(fl_level), .pump_en(pump_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_ack(output logic a);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    a = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_ack(a);
  endtask

  task automatic write3(input logic [7:0] ad, input logic [7:0] se,
                        input logic [7:0] da, output logic [2:0] acks);
    logic a0, a1, a2;
    bus_start();
    send_byte(ad, a0);
    send_byte(se, a1);
    send_byte(da, a2);
    bus_stop();
    tick(4*Q);
    acks = {a0, a1, a2};
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] acks;
    logic a;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R9 reset state
    chk("R9 bl_level", bl_level, 0);
    chk("R9 bl_led4_en", bl_led4_en, 0);
    chk("R9 fl_level", fl_level, 0);
    chk("R9 pump_en", pump_en, 0);
    chk("R9 sda_oe", sda_oe, 0);

    // Vector table: R1 R2 R3 R4 R5 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      write3(VEC[v][40:33], VEC[v][32:25], VEC[v][24:17], acks);
      chk("R1/R2/R3 ack pattern", acks, VEC[v][16:14]);
      chk("R4/R10 bl_level", bl_level, VEC[v][13:9]);
      chk("R4 bl_led4_en", bl_led4_en, VEC[v][8]);
      chk("R5/R10 fl_level", fl_level, VEC[v][7:1]);
      chk("R8 pump_en", pump_en, VEC[v][0]);
    end

    // R6: commit before ACK/STOP, sampled in last data SCL high
    bus_start();
    send_byte(8'h72, a);
    send_byte(8'h01, a);
    for (int i = 7; i >= 1; i--) send_bit(8'h85 >> i);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    chk("R6 bl_level mid SCL high", bl_level, 5'h05);
    chk("R6 bl_led4_en mid SCL high", bl_led4_en, 1);
    chk("R6 sda_oe not yet driven", sda_oe, 0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
    get_ack(a);
    chk("R6 data ack", a, 1);
    chk("R8 pump_en after bl write", pump_en, 1);
    // R7: fourth byte ignored
    send_byte(8'h9F, a);
    chk("R7 fourth byte nack", a, 0);
    bus_stop();
    tick(4*Q);
    chk("R7 fourth byte no effect", bl_level, 5'h05);

    // R7: STOP after five data bits aborts
    bus_start();
    send_byte(8'h72, a);
    send_byte(8'h02, a);
    for (int i = 7; i >= 3; i--) send_bit(1'b1);
    bus_stop();
    tick(4*Q);
    chk("R7 stop abort fl_level", fl_level, 0);
    chk("R7 stop abort bl_level", bl_level, 5'h05);

    // R7: repeated START after three data bits aborts, new frame works
    bus_start();
    send_byte(8'h72, a);
    send_byte(8'h01, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'h72, a);
    send_byte(8'h02, a);
    send_byte(8'h33, a);
    bus_stop();
    tick(4*Q);
    chk("R7 restart abort bl_level", bl_level, 5'h05);
    chk("R7 restart abort bl_led4_en", bl_led4_en, 1);
    chk("R5 new frame fl_level", fl_level, 7'h33);

    // R9: reset after programming
    rst = 1'b1; tick(4);
    rst = 1'b0; tick(2);
    chk("R9 reset bl_level", bl_level, 0);
    chk("R9 reset bl_led4_en", bl_led4_en, 0);
    chk("R9 reset fl_level", fl_level, 0);
    chk("R9 reset pump_en", pump_en, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule